// File: doc/BRIEF.md
# External interrupt input controller

This block conditions a single external interrupt pin for a small microcontroller. The raw pin passes through a synchronizer. It is then gated by an input-enable bit and adjusted by a polarity bit. A rising edge of the resulting conditioned signal sets a request flag. When interrupts are enabled, the flag drives an interrupt request line. When interrupts are disabled, software polls the flag with a strobe that tests and clears it in one step and reports the result on a skip output.

The conditioned level also feeds a key-on wakeup request, which a separate enable bit qualifies. Because edge detection runs on the conditioned signal and not on the raw pin, rewriting the gate or polarity bit can produce an edge and set the flag. Software should expect this and clear the flag afterwards.

Three control registers are written through one synchronous port, chosen by `wr_sel_i`:

| `wr_sel_i` | Register | Bits used |
|---|---|---|
| 0 | pin control | `wr_data_i[3]` is the input enable, `wr_data_i[2]` is the polarity |
| 1 | interrupt enable | `wr_data_i[0]` |
| 2 | wakeup enable | `wr_data_i[0]` |

Top module: `ext_irq_ctrl`

## Requirements
- R1: While the input enable (pin control bit 3) is 0, pin activity never sets the flag.
- R2: Polarity (pin control bit 2) set to 0 makes a falling pin edge valid, and set to 1 makes a rising pin edge valid. The pin passes through two synchronizer flops, so the flag is set on the third rising clock edge after the pin changes. An edge of the other direction leaves the flag clear.
- R3: While interrupt enable bit 0 is 0, `poll_i` drives `skip_o` to 1 in the same cycle if and only if the flag is set, and it clears the flag at the next clock edge.
- R4: A write to pin control that raises the conditioned signal (pin level XNOR polarity, ANDed with the input enable) from 0 to 1 sets the flag. This applies to a change of the input enable and to a change of the polarity.
- R5: `irq_o` is 1 exactly when the flag is set and interrupt enable bit 0 is 1.
- R6: While interrupt enable bit 0 is 1, `poll_i` has no effect: `skip_o` stays 0 and the flag is kept.
- R7: `ack_i` clears the flag at the next clock edge.
- R8: A valid edge in the same cycle as a poll or acknowledge clear leaves the flag set.
- R9: `wakeup_o` is 1 when wakeup enable bit 0 is 1 and the conditioned signal is 1.
- R10: `wakeup_o` is 0 whenever the input enable is 0, whatever the wakeup enable holds.
- R11: After reset, all control bits and the flag are 0, and `irq_o`, `skip_o` and `wakeup_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 pin control, 1 interrupt enable, 2 wakeup enable |
| wr_data_i | input | 4 | Write data |
| poll_i | input | 1 | Test-and-clear strobe for the flag |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| pin_i | input | 1 | Raw external pin |
| irq_o | output | 1 | Interrupt request |
| skip_o | output | 1 | Poll result, 1 when the flag was set |
| wakeup_o | output | 1 | Key-on wakeup request |

## Verification
Assertions check the following on every cycle:
- a detected edge always leaves the flag set, even during a clear;
- a poll or acknowledge without a competing edge clears the flag;
- a poll while interrupts are enabled keeps the flag;
- irq never appears without the enable;
- wakeup stays low while the input is gated off.

Other behaviours need the bench's scenarios:
- which edge direction each polarity accepts;
- that a pin-control write alone creates an edge;
- the synchronizer latency;
- the coincidence of an edge with a poll.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_IE   = 2'd1,
    SEL_WAKE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned DATA_W     = 4;
  localparam int unsigned IN_EN_BIT  = 3;
  localparam int unsigned POL_BIT    = 2;
  localparam int unsigned ENABLE_BIT = 0;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ext_irq_cfg.sv
module ext_irq_cfg
  import ext_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              in_en_o,
  output logic              pol_o,
  output logic              ie_o,
  output logic              wk_en_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_en_o <= 1'b0;
      pol_o   <= 1'b0;
      ie_o    <= 1'b0;
      wk_en_o <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_PIN: begin
          in_en_o <= wr_data_i[IN_EN_BIT];
          pol_o   <= wr_data_i[POL_BIT];
        end
        SEL_IE:   ie_o    <= wr_data_i[ENABLE_BIT];
        SEL_WAKE: wk_en_o <= wr_data_i[ENABLE_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_sync_i,
  input  logic in_en_i,
  input  logic pol_i,
  input  logic ie_i,
  input  logic poll_i,
  input  logic ack_i,
  output logic cond_o,
  output logic flag_o,
  output logic skip_o
);
  logic cond_q, edge_det, poll_ok;

  // polarity 1 passes the pin, 0 inverts it; disabled input reads low
  assign cond_o   = in_en_i & (pin_sync_i ^ ~pol_i);
  assign edge_det = cond_o & ~cond_q;
  assign poll_ok  = poll_i & ~ie_i;
  assign skip_o   = poll_ok & flag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      cond_q <= cond_o;
      if (edge_det)              flag_o <= 1'b1;
      else if (poll_ok || ack_i) flag_o <= 1'b0;
    end
  end

  a_r8_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_det |=> flag_o);
  a_r3_poll_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && !edge_det) |=> !flag_o);
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !edge_det) |=> !flag_o);
  a_r6_poll_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && ie_i && !ack_i && flag_o) |=> flag_o);
  a_r6_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_i |-> !skip_o);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              poll_i,
  input  logic              ack_i,
  input  logic              pin_i,
  output logic              irq_o,
  output logic              skip_o,
  output logic              wakeup_o
);
  logic pin_sync, in_en, pol, ie, wk_en, cond, flag;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  ext_irq_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .in_en_o   (in_en),
    .pol_o     (pol),
    .ie_o      (ie),
    .wk_en_o   (wk_en)
  );

  ext_irq_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .in_en_i    (in_en),
    .pol_i      (pol),
    .ie_i       (ie),
    .poll_i     (poll_i),
    .ack_i      (ack_i),
    .cond_o     (cond),
    .flag_o     (flag),
    .skip_o     (skip_o)
  );

  assign irq_o    = flag & ie;
  assign wakeup_o = wk_en & in_en & cond;

  a_r5_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie);
  a_r10_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_en |-> !wakeup_o);
  a_r1_no_flag_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_en && !flag) |=> !flag);
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic       poll = 1'b0;
  logic       ack = 1'b0;
  logic       pin = 1'b0;
  logic       irq, skip, wakeup;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .poll_i    (poll),
    .ack_i     (ack),
    .pin_i     (pin),
    .irq_o     (irq),
    .skip_o    (skip),
    .wakeup_o  (wakeup)
  );

  // {polarity, pin before, pin after, expected skip}
  localparam logic [3:0] VEC [4] = '{
    4'b0_1_0_1,
    4'b0_0_1_0,
    4'b1_0_1_1,
    4'b1_1_0_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_chk(input string req, input logic exp);
    @(negedge clk);
    poll = 1'b1;
    #1 check(req, skip, exp);
    @(negedge clk);
    poll = 1'b0;
  endtask

  task automatic clear_flag();
    repeat (2) begin
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    #1;
    check("R11 irq", irq, 1'b0);
    check("R11 skip", skip, 1'b0);
    check("R11 wakeup", wakeup, 1'b0);
    rst_n = 1'b1;
    poll_chk("R11 flag", 1'b0);

    // table: polarity and edge direction
    foreach (VEC[i]) begin
      wr(2'd0, {1'b1, VEC[i][3], 2'b00});
      pin = VEC[i][2];
      idle(5);
      clear_flag();
      pin = VEC[i][1];
      idle(5);
      poll_chk("R2 edge", VEC[i][0]);
      poll_chk("R3 cleared", 1'b0);
    end

    // R1: gated input ignores pin edges
    pin = 1'b1;
    wr(2'd0, 4'b0000);
    idle(4);
    clear_flag();
    pin = 1'b0; idle(5);
    pin = 1'b1; idle(5);
    pin = 1'b0; idle(5);
    poll_chk("R1 gated", 1'b0);

    // R4: enabling input with pin low, falling polarity
    wr(2'd0, 4'b1000);
    poll_chk("R4 enable edge", 1'b1);

    // R4: polarity flip with pin high
    pin = 1'b1; idle(5);
    clear_flag();
    wr(2'd0, 4'b1100);
    poll_chk("R4 polarity edge", 1'b1);

    // R5/R6/R7: interrupt path
    wr(2'd1, 4'b0001);
    pin = 1'b0; idle(5);
    pin = 1'b1; idle(5);
    #1 check("R5 irq set", irq, 1'b1);
    poll_chk("R6 no skip", 1'b0);
    #1 check("R6 flag kept", irq, 1'b1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1 check("R7 ack clears", irq, 1'b0);
    wr(2'd1, 4'b0000);

    // R8: write-created edge lands in the same cycle as a poll
    wr(2'd0, 4'b0000);
    pin = 1'b0; idle(4);
    wr(2'd0, 4'b1000);
    wr(2'd0, 4'b0000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; poll = 1'b1;
    #1 check("R8 flag before", skip, 1'b1);
    @(negedge clk); poll = 1'b0;
    poll_chk("R8 edge wins", 1'b1);
    poll_chk("R3 poll cleared", 1'b0);

    // R9/R10: wakeup
    wr(2'd2, 4'b0001);
    #1 check("R9 wakeup", wakeup, 1'b1);
    pin = 1'b1; idle(4);
    #1 check("R9 wakeup follows level", wakeup, 1'b0);
    pin = 1'b0; idle(4);
    wr(2'd0, 4'b0000);
    #1 check("R10 gated wakeup", wakeup, 1'b0);
    wr(2'd2, 4'b0000);
    wr(2'd0, 4'b1000);
    #1 check("R9 wake disabled", wakeup, 1'b0);

    // R11: reset mid-run clears everything
    wr(2'd1, 4'b0001);
    #1 check("R5 irq from write edge", irq, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R11 irq after reset", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    poll_chk("R11 ie cleared", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule